// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides, every cycle, where the two source operands of the instruction now in the execute stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) come from: the register file, the result held in the execute-to-memory pipeline register, or the result held in the memory-to-writeback pipeline register. It keeps its own copy of the hazard-relevant fields of those pipeline registers: destination index, write-enable and load flag. The selects therefore always follow the live pipeline contents and never a decision frozen at decode. This matters because an instruction can sit in a stage for more than one cycle.

When the instruction in decode needs a value that a load now in execute will only return at the end of the memory stage, no bypass path can deliver it in time. The block then raises a stall, which holds fetch and decode, and signals a bubble: the entry that enters execute next cycle has every write-enable and memory-enable cleared, while the older instructions keep moving. The decode stage presents one instruction record per cycle. While the stall is high it presents the same record again.

The register file is assumed to write in the first half of the cycle and read in the second. A writeback and a decode read of the same register in one cycle is therefore handled outside this block.

Top module: `fwd_interlock_top`

## Requirements
- R1: After reset all tracked pipeline entries are empty: both selects read 0 (register file), and stall and bubble are low.
- R2: A select reads 1 (execute-to-memory result) when the execute instruction uses that source, the source is nonzero, and the execute-to-memory entry writes that register.
- R3: A select reads 2 (memory-to-writeback result) when the source is used and nonzero, the memory-to-writeback entry writes that register, and the execute-to-memory entry does not.
- R4: When both downstream entries write the same register that a used source names, the younger one wins and the select reads 1.
- R5: Register 0 never causes forwarding or a stall. A source of 0 always selects 0.
- R6: When the execute entry is a load that writes a register named by a used source of a valid decode record, stall and bubble are both 1 in that same cycle.
- R7: A load-use stall lasts exactly one cycle. When the held consumer reaches execute, its select reads 2.
- R8: A source whose use flag is clear, or a decode record marked not valid, never stalls. The entry it leaves behind never causes forwarding.
- R9: A non-load producer directly ahead of its consumer causes no stall. Its result is forwarded with select 1.
- R10: An entry with its write-enable clear never causes forwarding or a stall, whatever its destination field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decode slot holds a real instruction |
| decRs1 | input | REG_BITS | First source register of the decode instruction |
| decRs2 | input | REG_BITS | Second source register of the decode instruction |
| decUse1 | input | 1 | First source is actually read |
| decUse2 | input | 1 | Second source is actually read |
| decRd | input | REG_BITS | Destination register of the decode instruction |
| decRegWr | input | 1 | Decode instruction writes its destination |
| decIsLoad | input | 1 | Decode instruction is a load |
| fwdSelA | output | 2 | First-operand select: 0 register file, 1 execute-to-memory, 2 memory-to-writeback |
| fwdSelB | output | 2 | Second-operand select, same encoding |
| stallUp | output | 1 | Hold fetch and decode this cycle |
| bubbleIns | output | 1 | Next execute entry is an empty bubble |

## Verification
The assertions assume that the decode record stays stable through a stall cycle, since upstream is held, and that the clock and reset are well formed. Under that assumption a stall can never be followed at once by another stall, and a stall can only appear behind a write-enabled load. The stimulus keeps to the assumption by re-presenting the held record whenever its model predicts a stall. Register indices are drawn from a small range so that matches against one, both or neither downstream entry happen often. Valid and use flags are toggled at random so that the gating terms are exercised.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] exMemHit;
    logic [NUM_SRC-1:0] memWbHit;
    logic [NUM_SRC-1:0] loadUseHit;
  } hzdMatch_t;

  typedef struct packed {
    logic                    stall;
    logic                    bubble;
    logic [NUM_SRC-1:0][1:0] fwdSel;
  } hzdStrobe_t;
endpackage

// File: rtl/fwd_track_dp.sv
module fwd_track_dp
  import fwd_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             decValid,
  input  logic [NUM_SRC-1:0][REG_BITS-1:0] decRs,
  input  logic [NUM_SRC-1:0]               decUse,
  input  logic [REG_BITS-1:0]              decRd,
  input  logic                             decRegWr,
  input  logic                             decIsLoad,
  input  hzdStrobe_t                       strobe,
  output hzdMatch_t                        match
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  typedef struct packed {
    logic [NUM_SRC-1:0][REG_BITS-1:0] rs;
    logic [NUM_SRC-1:0]               srcUsed;
    logic [REG_BITS-1:0]              rd;
    logic                             regWr;
    logic                             isLoad;
  } exEntry_t;

  typedef struct packed {
    logic [REG_BITS-1:0] rd;
    logic                regWr;
  } wrEntry_t;

  exEntry_t decEntry, idEx;
  wrEntry_t exMem, memWb;

  always_comb begin
    decEntry.rs      = decRs;
    decEntry.srcUsed = decUse;
    decEntry.rd      = decRd;
    decEntry.regWr   = decRegWr;
    decEntry.isLoad  = decIsLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idEx  <= '0;
      exMem <= '0;
      memWb <= '0;
    end else begin
      idEx        <= (strobe.bubble || !decValid) ? '0 : decEntry;
      exMem.rd    <= idEx.rd;
      exMem.regWr <= idEx.regWr;
      memWb       <= exMem;
    end
  end

  logic [NUM_SRC-1:0] memHitV, wbHitV, luHitV;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic exLive;
    assign exLive     = idEx.srcUsed[g] && (idEx.rs[g] != ZERO_REG);
    assign memHitV[g] = exLive && exMem.regWr && (exMem.rd == idEx.rs[g]);
    assign wbHitV[g]  = exLive && memWb.regWr && (memWb.rd == idEx.rs[g]);
    assign luHitV[g]  = decValid && decUse[g] && (decRs[g] != ZERO_REG) &&
                        idEx.regWr && idEx.isLoad && (idEx.rd == decRs[g]);

    a_r5_zero_src: assert property (@(posedge clk) disable iff (!rstN)
      (idEx.rs[g] == ZERO_REG) |-> (strobe.fwdSel[g] == FWD_RF));

    a_r4_young_wins: assert property (@(posedge clk) disable iff (!rstN)
      (idEx.srcUsed[g] && idEx.rs[g] != ZERO_REG && exMem.regWr &&
       exMem.rd == idEx.rs[g]) |-> (strobe.fwdSel[g] == FWD_MEM));

    a_r10_no_writer: assert property (@(posedge clk) disable iff (!rstN)
      (!exMem.regWr && !memWb.regWr) |-> (strobe.fwdSel[g] == FWD_RF));
  end

  assign match = '{exMemHit: memHitV, memWbHit: wbHitV, loadUseHit: luHitV};

  a_r6_stall_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |-> (idEx.isLoad && idEx.regWr && decValid));

  a_r7_stall_single: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |=> !strobe.stall);
endmodule

// File: rtl/fwd_hazard_ctl.sv
module fwd_hazard_ctl
  import fwd_pkg::*;
(
  input  hzdMatch_t  match,
  output hzdStrobe_t strobe
);
  logic [NUM_SRC-1:0][1:0] selV;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    always_comb begin
      if (match.exMemHit[g])      selV[g] = FWD_MEM;
      else if (match.memWbHit[g]) selV[g] = FWD_WB;
      else                        selV[g] = FWD_RF;
    end
  end

  logic lu;
  assign lu = |match.loadUseHit;

  assign strobe = '{stall: lu, bubble: lu, fwdSel: selV};
endmodule

// File: rtl/fwd_interlock_top.sv
module fwd_interlock_top
  import fwd_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                decValid,
  input  logic [REG_BITS-1:0] decRs1,
  input  logic [REG_BITS-1:0] decRs2,
  input  logic                decUse1,
  input  logic                decUse2,
  input  logic [REG_BITS-1:0] decRd,
  input  logic                decRegWr,
  input  logic                decIsLoad,
  output logic [1:0]          fwdSelA,
  output logic [1:0]          fwdSelB,
  output logic                stallUp,
  output logic                bubbleIns
);
  logic [NUM_SRC-1:0][REG_BITS-1:0] srcIdx;
  logic [NUM_SRC-1:0]               srcUse;
  hzdMatch_t  match;
  hzdStrobe_t strobe;

  assign srcIdx[0] = decRs1;
  assign srcIdx[1] = decRs2;
  assign srcUse    = {decUse2, decUse1};

  fwd_track_dp #(.REG_BITS(REG_BITS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .decValid  (decValid),
    .decRs     (srcIdx),
    .decUse    (srcUse),
    .decRd     (decRd),
    .decRegWr  (decRegWr),
    .decIsLoad (decIsLoad),
    .strobe    (strobe),
    .match     (match)
  );

  fwd_hazard_ctl i_ctl (
    .match  (match),
    .strobe (strobe)
  );

  assign fwdSelA   = strobe.fwdSel[0];
  assign fwdSelB   = strobe.fwdSel[1];
  assign stallUp   = strobe.stall;
  assign bubbleIns = strobe.bubble;
endmodule

// File: tb/test_fwd_interlock_top.sv
module test_fwd_interlock_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, decValid, decUse1, decUse2, decRegWr, decIsLoad;
  logic [4:0] decRs1, decRs2, decRd;
  logic [1:0] fwdSelA, fwdSelB;
  logic       stallUp, bubbleIns;

  fwd_interlock_top #(.REG_BITS(5)) i_fwd_interlock_top (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decRs1(decRs1), .decRs2(decRs2),
    .decUse1(decUse1), .decUse2(decUse2), .decRd(decRd), .decRegWr(decRegWr),
    .decIsLoad(decIsLoad), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallUp(stallUp), .bubbleIns(bubbleIns)
  );

  typedef struct {
    logic [4:0] rd, rs1, rs2;
    logic       u1, u2, wr, ld;
  } rec_t;

  rec_t mIdEx, mExMem, mMemWb;
  int   nChk = 0, nFail = 0;

  function automatic rec_t mk(int rd, int rs1, int rs2, bit u1, bit u2, bit wr, bit ld);
    rec_t r;
    r.rd = rd[4:0]; r.rs1 = rs1[4:0]; r.rs2 = rs2[4:0];
    r.u1 = u1; r.u2 = u2; r.wr = wr; r.ld = ld;
    return r;
  endfunction

  function automatic int expSel(logic [4:0] src, logic u, rec_t em, rec_t mw);
    if (!u || src == 5'd0) return 0;
    if (em.wr && em.rd == src) return 1;
    if (mw.wr && mw.rd == src) return 2;
    return 0;
  endfunction

  function automatic bit expStall(rec_t d, bit v, rec_t ie);
    if (!v || !ie.ld || !ie.wr || ie.rd == 5'd0) return 0;
    return (d.u1 && d.rs1 == ie.rd) || (d.u2 && d.rs2 == ie.rd);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(rec_t d, bit v, string tag, output bit st);
    bit es;
    @(negedge clk);
    decValid = v; decRs1 = d.rs1; decRs2 = d.rs2; decUse1 = d.u1; decUse2 = d.u2;
    decRd = d.rd; decRegWr = d.wr; decIsLoad = d.ld;
    #1;
    es = expStall(d, v, mIdEx);
    check(tag, "stall", int'(stallUp), int'(es));
    check(tag, "bubble", int'(bubbleIns), int'(es));
    check(tag, "selA", int'(fwdSelA), expSel(mIdEx.rs1, mIdEx.u1, mExMem, mMemWb));
    check(tag, "selB", int'(fwdSelB), expSel(mIdEx.rs2, mIdEx.u2, mExMem, mMemWb));
    mMemWb = mExMem;
    mExMem = mIdEx;
    mIdEx  = (es || !v) ? mk(0, 0, 0, 0, 0, 0, 0) : d;
    st = es;
  endtask

  task automatic run(rec_t d, string tag);
    bit st;
    step(d, 1'b1, tag, st);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    nFail++;
    $display("FAIL watchdog R1: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    rec_t nop, pend;
    bit st, pv, havePend;
    int seed;
    nop = mk(0, 0, 0, 0, 0, 0, 0);
    mIdEx = nop; mExMem = nop; mMemWb = nop;
    rstN = 1'b0; decValid = 0; decRs1 = 0; decRs2 = 0; decUse1 = 0; decUse2 = 0;
    decRd = 0; decRegWr = 0; decIsLoad = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    step(nop, 1'b0, "R1", st);
    run(nop, "R1");
    // R2: back-to-back ALU, select 1
    run(mk(1, 0, 0, 0, 0, 1, 0), "R2");
    run(mk(8, 1, 0, 1, 0, 1, 0), "R2");
    run(nop, "R2");
    // R3: one-gap producer, select 2 on second operand
    run(mk(2, 0, 0, 0, 0, 1, 0), "R3");
    run(nop, "R3");
    run(mk(9, 0, 2, 0, 1, 1, 0), "R3");
    run(nop, "R3");
    // R4: two producers of the same register
    run(mk(3, 0, 0, 0, 0, 1, 0), "R4");
    run(mk(3, 0, 0, 0, 0, 1, 0), "R4");
    run(mk(10, 3, 3, 1, 1, 1, 0), "R4");
    run(nop, "R4");
    // R5: register zero
    run(mk(0, 0, 0, 0, 0, 1, 1), "R5");
    run(mk(11, 0, 0, 1, 1, 1, 0), "R5");
    run(nop, "R5");
    // R6 and R7: load followed at once by a use
    run(mk(4, 0, 0, 0, 0, 1, 1), "R6");
    step(mk(12, 4, 0, 1, 0, 1, 0), 1'b1, "R6", st);
    if (!st) begin nChk++; nFail++; $display("FAIL R6 model: actual 0 expected 1"); end
    run(mk(12, 4, 0, 1, 0, 1, 0), "R7");
    run(nop, "R7");
    run(nop, "R7");
    // R8: unused source and invalid slot
    run(mk(5, 0, 0, 0, 0, 1, 1), "R8");
    run(mk(13, 5, 5, 0, 0, 1, 0), "R8");
    run(mk(5, 0, 0, 0, 0, 1, 1), "R8");
    step(mk(5, 5, 5, 1, 1, 1, 0), 1'b0, "R8", st);
    run(mk(0, 5, 0, 1, 0, 0, 0), "R8");
    run(nop, "R8");
    // R9: ALU producer never stalls
    run(mk(6, 0, 0, 0, 0, 1, 0), "R9");
    run(mk(14, 6, 6, 1, 1, 1, 0), "R9");
    run(nop, "R9");
    // R10: non-writing producer, even a load
    run(mk(7, 0, 0, 0, 0, 0, 1), "R10");
    run(mk(15, 7, 7, 1, 1, 1, 0), "R10");
    run(nop, "R10");
    run(nop, "R10");

    // random mix, covers R2 R3 R4 R6 R7 R8
    seed = $urandom(32'd1234);
    havePend = 0; pv = 1;
    for (int i = 0; i < 4000; i++) begin
      if (!havePend) begin
        pend = mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0,
                  $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
        pv = $urandom_range(0, 7) != 0;
      end
      step(pend, pv, "random-R6", st);
      havePend = st;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule